// File: doc/BRIEF.md
# Processor Interrupt Entry and Return Sequencer

This block sits between three interrupt request lines (machine check, critical, external input) and the program counter and machine state register of a simple in-order core. When a request is pending and its enable bit in the state register is set, the block picks the most urgent one. It asks the pipeline to drain and waits for the pipeline to report that the drain is done. It then saves the return address and the whole state register, and trims the state register down to handler mode. Last, it redirects fetch to a handler address. That address is built from a programmable prefix register and a programmable offset register chosen by the cause.

A return strobe puts the saved state back and redirects fetch to the saved address. Software reaches the state register through a write port. This is how a handler sets the external enable again. The prefix and offset registers are loaded through a small configuration write port. The pipeline, the address translation unit and the upstream interrupt controller are outside the block.

Top module: `irq_entry_unit`

## Requirements
- R1: The entry redirect address is {prefix[15:0], offset[15:4], 4'b0000}, with address bit 31 as the MSB, so its low four bits are always zero.
- R2: Configuration write selector codes are 7 = prefix, 0 = critical offset, 1 = machine check offset and 4 = external offset. Any other selector code is ignored. Data bits [3:0] of an offset write are dropped.
- R3: When several enabled requests compete, machine check wins over critical, and critical wins over external input.
- R4: The enable bits in the state register are bit 15 (external), bit 17 (critical) and bit 12 (machine check). A request whose enable bit is clear is not taken. Because entry clears bit 15, a held external request cannot re-enter the handler.
- R5: The machine check line is edge-triggered. A rising edge stays pending while the enable bit is clear and is taken once the enable bit is set. Taking it clears the pending flag.
- R6: drain_req rises the cycle after a request wins and stays high until drain_done is seen. redirect_valid pulses for one cycle, in the cycle after the cycle in which drain_done was seen. After reset, drain_req, redirect_valid and the state register are zero.
- R7: Critical and external requests are level-sensitive. If the winning level request is no longer asserted when drain_done arrives, the entry is abandoned. No redirect is issued and the state register is left unchanged.
- R8: On entry, srr0_out takes the value of cur_pc and srr1_out takes the full state register, both as they were in the drain_done cycle.
- R9: On entry, state bits 17, 12 and 9 keep their values and every other bit is cleared. Cleared bits include bit 14 (user mode), bit 15 (external enable) and bits 5 and 4 (address space selects).
- R10: A return strobe while no entry is in progress copies srr1_out into the state register and pulses redirect_valid with redirect_pc equal to srr0_out, one cycle later.
- R11: A state write, when no entry or return is in progress, loads st_wr_data into the state register on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_mchk | input | 1 | Machine check request, edge-triggered |
| irq_crit | input | 1 | Critical request, level |
| irq_ext | input | 1 | External input request, level |
| cur_pc | input | 32 | Address to return to if an entry completes this cycle |
| drain_req | output | 1 | Request to drain the instruction queue |
| drain_done | input | 1 | Pipeline reports the drain has finished |
| redirect_valid | output | 1 | One-cycle fetch redirect strobe |
| redirect_pc | output | 32 | Fetch redirect target |
| rfi | input | 1 | Return-from-interrupt strobe |
| st_wr_en | input | 1 | Software write of the state register |
| st_wr_data | input | 32 | State register write data |
| state_out | output | 32 | Current machine state register |
| srr0_out | output | 32 | Saved return address |
| srr1_out | output | 32 | Saved state register |
| cfg_wr_en | input | 1 | Prefix/offset register write strobe |
| cfg_wr_sel | input | 3 | Prefix/offset register selector |
| cfg_wr_data | input | 16 | Prefix/offset write data |

## Verification
The bound checker checks on every cycle that:
- drain_req holds until the handshake completes;
- every entry redirect is 16-byte aligned;
- the trimmed state and the two saved registers match the values from the cycle before;
- a return restores the saved pair;
- an abandoned entry leaves the state register untouched.

Only the bench scenarios can show which cause wins, which offset register the address came from, and that a disabled or already-masked request is never taken. The same holds for a machine check edge that stays pending across a period with its enable bit clear.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE = 2'd0,
    CAUSE_CRIT = 2'd1,
    CAUSE_MCHK = 2'd2,
    CAUSE_EXT  = 2'd3
  } cause_e;

  typedef enum logic {
    SEQ_IDLE  = 1'b0,
    SEQ_DRAIN = 1'b1
  } seq_e;

  // state register bit positions
  localparam int BIT_EE = 15;
  localparam int BIT_CE = 17;
  localparam int BIT_ME = 12;
  localparam int BIT_DE = 9;

  // configuration selector codes
  localparam int NUM_OFFS = 3;  // index 0 crit, 1 mchk, 2 ext
  localparam logic [2:0] OFF_SEL [NUM_OFFS] = '{3'd0, 3'd1, 3'd4};
  localparam logic [2:0] PREFIX_SEL = 3'd7;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/irq_edge_latch.sv
module irq_edge_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic clr,
  output logic pend
);
  logic prev_q, prev_d;
  logic pend_q, pend_d;
  logic rise;

  always_comb begin
    rise   = req & ~prev_q;
    prev_d = req;
    pend_d = (pend_q & ~clr) | rise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= prev_d;
      pend_q <= pend_d;
    end
  end

  // an edge seen this cycle counts at once so it can win arbitration
  assign pend = pend_q | rise;
endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb
  import irq_entry_pkg::*;
(
  input  logic   mchk_pend,
  input  logic   crit_req,
  input  logic   ext_req,
  input  logic   en_me,
  input  logic   en_ce,
  input  logic   en_ee,
  output cause_e winner
);
  always_comb begin
    if (mchk_pend && en_me)     winner = CAUSE_MCHK;
    else if (crit_req && en_ce) winner = CAUSE_CRIT;
    else if (ext_req && en_ee)  winner = CAUSE_EXT;
    else                        winner = CAUSE_NONE;
  end
endmodule

// File: rtl/irq_vec_regs.sv
module irq_vec_regs
  import irq_entry_pkg::*;
#(
  parameter int PREFIX_W = 16,
  parameter int OFFS_W   = 12,
  parameter int ALIGN_W  = 4,
  localparam int AW      = PREFIX_W + OFFS_W + ALIGN_W,
  localparam int OREG_W  = OFFS_W + ALIGN_W,
  localparam int CFG_W   = (PREFIX_W > OREG_W) ? PREFIX_W : OREG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr_en,
  input  logic [2:0]       cfg_wr_sel,
  input  logic [CFG_W-1:0] cfg_wr_data,
  input  cause_e           sel_cause,
  output logic [AW-1:0]    vec
);
  logic [PREFIX_W-1:0] prefix_q, prefix_d;
  logic [OFFS_W-1:0]   offs_q [NUM_OFFS];
  logic [OFFS_W-1:0]   offs_d [NUM_OFFS];
  logic [OFFS_W-1:0]   offs_sel;
  logic                unused_low;

  assign unused_low = ^cfg_wr_data[ALIGN_W-1:0];

  always_comb begin
    prefix_d = prefix_q;
    if (cfg_wr_en && cfg_wr_sel == PREFIX_SEL) prefix_d = cfg_wr_data[PREFIX_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prefix_q <= '0;
    else        prefix_q <= prefix_d;
  end

  for (genvar g = 0; g < NUM_OFFS; g++) begin : g_off
    always_comb begin
      offs_d[g] = offs_q[g];
      if (cfg_wr_en && cfg_wr_sel == OFF_SEL[g])
        offs_d[g] = cfg_wr_data[OREG_W-1:ALIGN_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) offs_q[g] <= '0;
      else        offs_q[g] <= offs_d[g];
    end
  end

  always_comb begin
    case (sel_cause)
      CAUSE_CRIT: offs_sel = offs_q[0];
      CAUSE_MCHK: offs_sel = offs_q[1];
      CAUSE_EXT:  offs_sel = offs_q[2];
      default:    offs_sel = '0;
    endcase
    vec = {prefix_q, offs_sel, {ALIGN_W{1'b0}}};
  end
endmodule

// File: rtl/irq_entry_unit.sv
module irq_entry_unit
  import irq_entry_pkg::*;
#(
  parameter int PREFIX_W = 16,
  parameter int OFFS_W   = 12,
  parameter int ALIGN_W  = 4,
  parameter int ST_W     = 32,
  localparam int AW      = PREFIX_W + OFFS_W + ALIGN_W,
  localparam int OREG_W  = OFFS_W + ALIGN_W,
  localparam int CFG_W   = (PREFIX_W > OREG_W) ? PREFIX_W : OREG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             irq_mchk,
  input  logic             irq_crit,
  input  logic             irq_ext,
  input  logic [AW-1:0]    cur_pc,
  output logic             drain_req,
  input  logic             drain_done,
  output logic             redirect_valid,
  output logic [AW-1:0]    redirect_pc,
  input  logic             rfi,
  input  logic             st_wr_en,
  input  logic [ST_W-1:0]  st_wr_data,
  output logic [ST_W-1:0]  state_out,
  output logic [AW-1:0]    srr0_out,
  output logic [ST_W-1:0]  srr1_out,
  input  logic             cfg_wr_en,
  input  logic [2:0]       cfg_wr_sel,
  input  logic [CFG_W-1:0] cfg_wr_data
);
  localparam logic [ST_W-1:0] KEEP_MASK =
    (ST_W'(1) << BIT_CE) | (ST_W'(1) << BIT_ME) | (ST_W'(1) << BIT_DE);

  logic           rst_n_s;
  seq_e           seq_q, seq_d;
  cause_e         cause_q, cause_d, winner;
  logic [ST_W-1:0] st_q, st_d, srr1_q, srr1_d;
  logic [AW-1:0]  srr0_q, srr0_d, rpc_q, rpc_d, vec;
  logic           rv_q, rv_d;
  logic           mchk_pend, commit, still_req;

  irq_rst_sync u_rst (.clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_n_s));

  irq_edge_latch u_mchk (
    .clk(clk), .rst_n(rst_n_s), .req(irq_mchk),
    .clr(commit && cause_q == CAUSE_MCHK), .pend(mchk_pend)
  );

  irq_prio_arb u_arb (
    .mchk_pend(mchk_pend), .crit_req(irq_crit), .ext_req(irq_ext),
    .en_me(st_q[BIT_ME]), .en_ce(st_q[BIT_CE]), .en_ee(st_q[BIT_EE]),
    .winner(winner)
  );

  irq_vec_regs #(.PREFIX_W(PREFIX_W), .OFFS_W(OFFS_W), .ALIGN_W(ALIGN_W)) u_vec (
    .clk(clk), .rst_n(rst_n_s), .cfg_wr_en(cfg_wr_en), .cfg_wr_sel(cfg_wr_sel),
    .cfg_wr_data(cfg_wr_data), .sel_cause(cause_q), .vec(vec)
  );

  always_comb begin
    case (cause_q)
      CAUSE_CRIT: still_req = irq_crit;
      CAUSE_EXT:  still_req = irq_ext;
      CAUSE_MCHK: still_req = mchk_pend;
      default:    still_req = 1'b0;
    endcase
  end

  always_comb begin
    seq_d   = seq_q;
    cause_d = cause_q;
    st_d    = st_q;
    srr0_d  = srr0_q;
    srr1_d  = srr1_q;
    rpc_d   = rpc_q;
    rv_d    = 1'b0;
    commit  = 1'b0;
    case (seq_q)
      SEQ_IDLE: begin
        if (rfi) begin
          st_d  = srr1_q;
          rpc_d = srr0_q;
          rv_d  = 1'b1;
        end else if (st_wr_en) begin
          st_d = st_wr_data;
        end else if (winner != CAUSE_NONE) begin
          seq_d   = SEQ_DRAIN;
          cause_d = winner;
        end
      end
      SEQ_DRAIN: begin
        if (drain_done) begin
          seq_d = SEQ_IDLE;
          if (still_req) begin
            commit = 1'b1;
            srr0_d = cur_pc;
            srr1_d = st_q;
            st_d   = st_q & KEEP_MASK;
            rpc_d  = vec;
            rv_d   = 1'b1;
          end
        end
      end
      default: seq_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      seq_q   <= SEQ_IDLE;
      cause_q <= CAUSE_NONE;
      st_q    <= '0;
      srr0_q  <= '0;
      srr1_q  <= '0;
      rpc_q   <= '0;
      rv_q    <= 1'b0;
    end else begin
      seq_q   <= seq_d;
      cause_q <= cause_d;
      st_q    <= st_d;
      srr0_q  <= srr0_d;
      srr1_q  <= srr1_d;
      rpc_q   <= rpc_d;
      rv_q    <= rv_d;
    end
  end

  assign drain_req      = (seq_q == SEQ_DRAIN);
  assign redirect_valid = rv_q;
  assign redirect_pc    = rpc_q;
  assign state_out      = st_q;
  assign srr0_out       = srr0_q;
  assign srr1_out       = srr1_q;
endmodule

// File: rtl/irq_entry_unit_chk.sv
module irq_entry_unit_chk #(
  parameter int AW      = 32,
  parameter int ST_W    = 32,
  parameter int ALIGN_W = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            drain_req,
  input logic            drain_done,
  input logic            rfi,
  input logic            redirect_valid,
  input logic [AW-1:0]   redirect_pc,
  input logic [AW-1:0]   cur_pc,
  input logic [ST_W-1:0] state_out,
  input logic [AW-1:0]   srr0_out,
  input logic [ST_W-1:0] srr1_out
);
  localparam logic [ST_W-1:0] KEEP_MASK =
    (ST_W'(1) << 17) | (ST_W'(1) << 12) | (ST_W'(1) << 9);

  a_r6_drain_holds: assert property (@(posedge clk) disable iff (!rst_n)
    drain_req && !drain_done |=> drain_req);

  a_r1_vec_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    $past(drain_req && drain_done) && redirect_valid |-> redirect_pc[ALIGN_W-1:0] == '0);

  a_r9_state_trimmed: assert property (@(posedge clk) disable iff (!rst_n)
    $past(drain_req && drain_done) && redirect_valid |->
      state_out == ($past(state_out) & KEEP_MASK));

  a_r8_context_saved: assert property (@(posedge clk) disable iff (!rst_n)
    $past(drain_req && drain_done) && redirect_valid |->
      srr1_out == $past(state_out) && srr0_out == $past(cur_pc));

  a_r7_abandon_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
    $past(drain_req && drain_done) && !redirect_valid |-> $stable(state_out));

  a_r10_return_restores: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rfi && !drain_req) |->
      redirect_valid && redirect_pc == $past(srr0_out) && state_out == $past(srr1_out));
endmodule

bind irq_entry_unit irq_entry_unit_chk #(.AW(AW), .ST_W(ST_W), .ALIGN_W(ALIGN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .drain_req(drain_req), .drain_done(drain_done),
  .rfi(rfi), .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
  .cur_pc(cur_pc), .state_out(state_out), .srr0_out(srr0_out), .srr1_out(srr1_out)
);

// File: tb/irq_entry_unit_bench.sv
module irq_entry_unit_bench;
  localparam logic [31:0] EE = 32'h0000_8000, CE = 32'h0002_0000, ME = 32'h0000_1000;
  localparam logic [31:0] DE = 32'h0000_0200, PR = 32'h0000_4000;
  localparam logic [31:0] KEEP = CE | ME | DE;
  localparam logic [15:0] W_PRE = 16'hABCD, W_O0 = 16'h123F, W_O1 = 16'h0456, W_O4 = 16'h0F8A;

  // {state[31:0], mchk, crit, ext, expected: 0 none 1 crit 2 mchk 3 ext}
  localparam int NV = 8;
  localparam logic [36:0] TBL [NV] = '{
    {EE,                3'b001, 2'd3},
    {32'h0,             3'b001, 2'd0},
    {CE | EE,           3'b011, 2'd1},
    {ME | CE | EE,      3'b111, 2'd2},
    {ME,                3'b100, 2'd2},
    {CE | PR | DE | 32'h30, 3'b010, 2'd1},
    {EE,                3'b011, 2'd3},
    {CE,                3'b001, 2'd0}
  };

  logic        clk, rst_n, irq_mchk, irq_crit, irq_ext, drain_done, rfi;
  logic        st_wr_en, cfg_wr_en, drain_req, redirect_valid;
  logic [31:0] cur_pc, redirect_pc, st_wr_data, state_out, srr0_out, srr1_out;
  logic [2:0]  cfg_wr_sel;
  logic [15:0] cfg_wr_data;
  int checks = 0, errors = 0, cycles = 0;

  irq_entry_unit u_irq_entry_unit (
    .clk(clk), .rst_n(rst_n), .irq_mchk(irq_mchk), .irq_crit(irq_crit), .irq_ext(irq_ext),
    .cur_pc(cur_pc), .drain_req(drain_req), .drain_done(drain_done),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc), .rfi(rfi),
    .st_wr_en(st_wr_en), .st_wr_data(st_wr_data), .state_out(state_out),
    .srr0_out(srr0_out), .srr1_out(srr1_out), .cfg_wr_en(cfg_wr_en),
    .cfg_wr_sel(cfg_wr_sel), .cfg_wr_data(cfg_wr_data)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog: run hung, act %0d cycles exp fewer", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: act %h exp %h", req, act, exp);
    end
  endtask

  task automatic cfg_wr(logic [2:0] sel, logic [15:0] d);
    cfg_wr_en = 1'b1; cfg_wr_sel = sel; cfg_wr_data = d;
    tick();
    cfg_wr_en = 1'b0;
  endtask

  task automatic set_state(logic [31:0] v);
    st_wr_en = 1'b1; st_wr_data = v;
    tick();
    st_wr_en = 1'b0;
    chk("R11 state write", state_out, v);
  endtask

  task automatic do_rfi(logic [31:0] exp_st, logic [31:0] exp_pc);
    rfi = 1'b1;
    tick();
    rfi = 1'b0;
    chk("R10 rfi strobe", {31'b0, redirect_valid}, 32'd1);
    chk("R10 rfi target", redirect_pc, exp_pc);
    chk("R10 rfi state", state_out, exp_st);
  endtask

  function automatic logic [31:0] exp_vec(logic [1:0] c);
    logic [15:0] o;
    o = (c == 2'd1) ? W_O0 : (c == 2'd2) ? W_O1 : W_O4;
    return {W_PRE, o[15:4], 4'h0};
  endfunction

  initial begin
    rst_n = 1'b0; irq_mchk = 0; irq_crit = 0; irq_ext = 0; drain_done = 0; rfi = 0;
    st_wr_en = 0; st_wr_data = 0; cfg_wr_en = 0; cfg_wr_sel = 0; cfg_wr_data = 0; cur_pc = 0;
    repeat (3) tick();
    chk("R6 reset drain_req", {31'b0, drain_req}, 0);
    chk("R6 reset redirect", {31'b0, redirect_valid}, 0);
    chk("R6 reset state", state_out, 0);
    rst_n = 1'b1;
    repeat (3) tick();

    cfg_wr(3'd7, W_PRE); cfg_wr(3'd0, W_O0); cfg_wr(3'd1, W_O1); cfg_wr(3'd4, W_O4);
    cfg_wr(3'd2, 16'hFFFF);  // R2 unused selector, must not disturb any register
    cfg_wr(3'd5, 16'hFFFF);

    for (int i = 0; i < NV; i++) begin
      logic [31:0] st, pc;
      logic [1:0]  ex;
      logic        seen;
      st = TBL[i][36:5]; ex = TBL[i][1:0]; pc = 32'h4000_0000 + 32'(i * 16);
      set_state(st);
      cur_pc = pc;
      irq_mchk = TBL[i][4]; irq_crit = TBL[i][3]; irq_ext = TBL[i][2];
      seen = 1'b0;
      for (int k = 0; k < 6 && !seen; k++) begin
        tick();
        seen = drain_req;
      end
      if (ex == 2'd0) begin
        chk("R4 disabled request not taken", {31'b0, seen}, 0);
        irq_mchk = 0; irq_crit = 0; irq_ext = 0;
        tick();
      end else begin
        chk("R3 winner starts drain", {31'b0, seen}, 1);
        drain_done = 1'b1;
        tick();
        drain_done = 1'b0;
        irq_mchk = 0; irq_crit = 0; irq_ext = 0;
        chk("R6 redirect after drain_done", {31'b0, redirect_valid}, 1);
        chk("R1 R2 R3 vector per cause", redirect_pc, exp_vec(ex));
        chk("R8 srr0 saved", srr0_out, pc);
        chk("R8 srr1 saved", srr1_out, st);
        chk("R9 state trimmed", state_out, st & KEEP);
        do_rfi(st, pc);
        tick();
      end
    end

    // R5: machine check edge held pending while disabled
    set_state(32'h0);
    irq_mchk = 1'b1; tick(); irq_mchk = 1'b0;
    repeat (4) tick();
    chk("R5 no entry while ME clear", {31'b0, drain_req}, 0);
    set_state(ME);
    tick();
    chk("R5 pending edge taken", {31'b0, drain_req}, 1);
    cur_pc = 32'h0000_7770;
    drain_done = 1'b1; tick(); drain_done = 1'b0;
    chk("R5 mchk vector", redirect_pc, exp_vec(2'd2));
    do_rfi(ME, 32'h0000_7770);
    repeat (3) tick();
    chk("R5 pending cleared after taking", {31'b0, drain_req}, 0);

    // R6 hold and R7 abandon
    set_state(EE);
    irq_ext = 1'b1; tick();
    chk("R6 drain starts", {31'b0, drain_req}, 1);
    repeat (3) tick();
    chk("R6 drain held", {31'b0, drain_req}, 1);
    chk("R6 no early redirect", {31'b0, redirect_valid}, 0);
    irq_ext = 1'b0; drain_done = 1'b1; tick(); drain_done = 1'b0;
    chk("R7 abandoned no redirect", {31'b0, redirect_valid}, 0);
    chk("R7 state unchanged", state_out, EE);
    chk("R7 drain ends", {31'b0, drain_req}, 0);

    // R4: held external request does not re-enter once EE is cleared
    cur_pc = 32'h0000_9990;
    irq_ext = 1'b1; tick();
    drain_done = 1'b1; tick(); drain_done = 1'b0;
    chk("R4 ext entry", redirect_pc, exp_vec(2'd3));
    repeat (4) tick();
    chk("R4 no re-entry with EE cleared", {31'b0, drain_req}, 0);
    irq_ext = 1'b0;
    do_rfi(EE, 32'h0000_9990);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule